// File: doc/BRIEF.md
# Dual-Mode Processor Counter/Timer

This block is the counter/timer that sits beside one processor. A single mode input chooses how it behaves, and that input comes from a configuration register shared across processors. With the mode input low, the block is a limit-match timer. Its count rises by one step on every tick, and on reaching the programmed limit it returns to zero, sets a reached flag and asserts an interrupt.

With the mode input high, the same four word registers expose a 63-bit up-counter. The counter is read and loaded as two 32-bit halves and is started or stopped through a run bit. It never interrupts.

Ticks arrive on an enable input, one per 500 ns period, and each tick adds one unit of count bit 9. The low nine bits of every count value read as zero. Registers are selected by a 2-bit word index: 0 for byte offset 0x0, 1 for 0x4, 2 for 0x8 and 3 for 0xC.

The mode input is registered inside the block. A change of the mode input is seen when it differs from that registered copy, so its side effects are applied exactly once, in that cycle. In that cycle every register access is decoded in the old mode, and a tick is dropped.

Top module: `pct_timer`

## Requirements
- R1: After reset the block is in timer mode. Index 0 reads 0 (limit zero), index 1 reads 0, index 2 reads 0, index 3 reads 1 (run bit set), and the interrupt is low.
- R2: In timer mode each tick adds 0x200 to the count. Reading index 1 returns the count in bits 30:9, the reached flag in bit 31, and zeros in bits 8:0.
- R3: In timer mode with a nonzero limit L (bits 30:9), the tick that would make the count equal L sets the count to 0 and sets both the reached flag and the interrupt. With a zero limit the count runs freely and neither the flag nor the interrupt is set.
- R4: In timer mode, writing index 0 loads the limit from bits 30:9, clears the count and drops the interrupt. Writing index 2 loads the limit and keeps the count. Index 2 reads as zero.
- R5: In timer mode, reading index 0 returns the limit in bits 30:9. From the next cycle the reached flag and the interrupt are clear, unless a match occurs in the same cycle as the read, in which case the match wins.
- R6: In timer mode, a write to index 1 changes nothing.
- R7: Index 3 stores a run bit in bit 0 and reads it back. In timer mode, counting continues whatever the run bit holds.
- R8: In counter mode the 63-bit value advances by 0x200 per tick only while the run bit is 1. Index 0 returns value bits 62:32 in bits 30:0, with the reached flag in bit 31. Index 1 returns value bits 31:0. A carry from the low half reaches the high half in the same cycle.
- R9: In counter mode, writing index 0 loads value bits 62:32 from data bits 30:0. Writing index 1 loads value bits 31:9 from data bits 31:9. Either write clears the reached flag.
- R10: In counter mode, a tick at the maximum value 0x7FFF_FFFF_FFFF_FE00 wraps the value to 0 and sets the reached flag. The interrupt is never asserted in counter mode.
- R11: On a change from timer to counter mode, the interrupt drops, the limit becomes 0x7FFFFE00 (it reads back as that value after a return to timer mode), and counting holds still if the run bit is 0. A tick in the change cycle is dropped.
- R12: On a change from counter to timer mode, counting resumes on the next tick even when the run bit is 0, and the run bit keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-cycle tick, one count step |
| userMode | input | 1 | 1 selects counter mode, 0 timer mode |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (reads have side effects) |
| regAddr | input | 2 | Word index: 0/1/2/3 for offsets 0x0/0x4/0x8/0xC |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, combinational from the index |
| irq | output | 1 | Timer interrupt, level |

## Verification
The assertions assume the following about the inputs:
- At most one of a write and a tick occurs in a cycle.
- Reset is held long enough to be seen on a clock edge.
- The mode input is a plain level whose history since reset matches the block's registered copy.

The stimulus keeps within these assumptions. It never pairs a write with a tick, and it makes no register access in a cycle where the mode input changes. Those change cycles still carry ticks, so that the dropped-tick rule is exercised.

// File: rtl/pct_pkg.sv
package pct_pkg;

  typedef enum logic [1:0] {
    REG_TOP  = 2'd0,
    REG_LOW  = 2'd1,
    REG_LIMK = 2'd2,
    REG_RUN  = 2'd3
  } pct_reg_e;

  typedef struct packed {
    logic userMode;
    logic countEn;
    logic rstCnt;
    logic ldLimit;
    logic ldHigh;
    logic ldLow;
    logic ldRun;
    logic clrReached;
    logic clrIrq;
    logic forceMax;
  } pct_strobe_t;

endpackage

// File: rtl/pct_ctrl.sv
module pct_ctrl
  import pct_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  logic        userMode,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [1:0]  regAddr,
  input  logic        runBit,
  output pct_strobe_t stb
);
  logic modeQ;
  logic toUser, toTimer, inTrans;
  logic wrTop, wrLow, rdTop;

  always_ff @(posedge clk) begin
    if (!rstN) modeQ <= 1'b0;
    else       modeQ <= userMode;
  end

  assign toUser  = userMode && !modeQ;
  assign toTimer = !userMode && modeQ;
  assign inTrans = toUser || toTimer;

  assign wrTop = regWrEn && (regAddr == REG_TOP);
  assign wrLow = regWrEn && (regAddr == REG_LOW);
  assign rdTop = regRdEn && (regAddr == REG_TOP);

  always_comb begin
    stb            = '0;
    stb.userMode   = modeQ;
    stb.countEn    = tickEn && !inTrans && (!modeQ || runBit);
    stb.rstCnt     = wrTop && !modeQ;
    stb.ldLimit    = (wrTop && !modeQ) || (regWrEn && (regAddr == REG_LIMK));
    stb.ldHigh     = wrTop && modeQ;
    stb.ldLow      = wrLow && modeQ;
    stb.ldRun      = regWrEn && (regAddr == REG_RUN);
    stb.clrReached = (rdTop && !modeQ) || ((wrTop || wrLow) && modeQ);
    stb.clrIrq     = ((wrTop || rdTop) && !modeQ) || toUser;
    stb.forceMax   = toUser;
  end
endmodule

// File: rtl/pct_datapath.sv
module pct_datapath
  import pct_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 63,
  parameter int SUB_W  = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  pct_strobe_t       stb,
  input  logic [1:0]        rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              runBit,
  output logic              irq
);
  localparam int P_W  = CNT_W - SUB_W;
  localparam int LO_P = DATA_W - SUB_W;
  localparam int CM_W = DATA_W - 1 - SUB_W;
  localparam int HI_W = CNT_W - DATA_W;

  logic [P_W-1:0]  periodQ, nextPeriod;
  logic [CM_W-1:0] limitQ, nextLo;
  logic            reachedQ, irqQ, runQ;
  logic            matchHit, evtReach, evtIrq;

  assign nextLo   = periodQ[CM_W-1:0] + 1'b1;
  assign matchHit = (limitQ != '0) && (nextLo == limitQ);
  assign evtReach = stb.countEn && (stb.userMode ? (&periodQ) : matchHit);
  assign evtIrq   = stb.countEn && !stb.userMode && matchHit;

  always_comb begin
    if (stb.userMode)  nextPeriod = periodQ + 1'b1;
    else if (matchHit) nextPeriod = '0;
    else               nextPeriod = {{(P_W-CM_W){1'b0}}, nextLo};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodQ  <= '0;
      limitQ   <= '0;
      reachedQ <= 1'b0;
      irqQ     <= 1'b0;
      runQ     <= 1'b1;
    end else begin
      if (stb.rstCnt)       periodQ <= '0;
      else if (stb.ldHigh)  periodQ <= {wrData[HI_W-1:0], periodQ[LO_P-1:0]};
      else if (stb.ldLow)   periodQ <= {periodQ[P_W-1:LO_P], wrData[DATA_W-1:SUB_W]};
      else if (stb.countEn) periodQ <= nextPeriod;

      if (stb.forceMax)     limitQ <= '1;
      else if (stb.ldLimit) limitQ <= wrData[DATA_W-2:SUB_W];

      if (evtReach)            reachedQ <= 1'b1;
      else if (stb.clrReached) reachedQ <= 1'b0;

      if (evtIrq)          irqQ <= 1'b1;
      else if (stb.clrIrq) irqQ <= 1'b0;

      if (stb.ldRun) runQ <= wrData[0];
    end
  end

  always_comb begin
    rdData = '0;
    unique case (rdAddr)
      REG_TOP: rdData = stb.userMode ? {reachedQ, periodQ[P_W-1:LO_P]}
                                     : {1'b0, limitQ, {SUB_W{1'b0}}};
      REG_LOW: rdData = stb.userMode ? {periodQ[LO_P-1:0], {SUB_W{1'b0}}}
                                     : {reachedQ, periodQ[CM_W-1:0], {SUB_W{1'b0}}};
      REG_RUN: rdData = {{(DATA_W-1){1'b0}}, runQ};
      default: rdData = '0;
    endcase
  end

  assign runBit = runQ;
  assign irq    = irqQ;
endmodule

// File: rtl/pct_timer.sv
module pct_timer
  import pct_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 63,
  parameter int SUB_W  = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              userMode,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irq
);
  pct_strobe_t stb;
  logic        runBit;

  pct_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .userMode(userMode),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .runBit(runBit), .stb(stb)
  );

  pct_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SUB_W(SUB_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rdAddr(regAddr),
    .wrData(regWrData), .rdData(regRdData), .runBit(runBit), .irq(irq)
  );
endmodule

// File: rtl/pct_checker.sv
module pct_checker (
  input logic       clk,
  input logic       rstN,
  input logic       tickEn,
  input logic       userMode,
  input logic       regWrEn,
  input logic       regRdEn,
  input logic [1:0] regAddr,
  input logic       irq
);
  p_user_no_irq_r10: assert property (@(posedge clk) disable iff (!rstN)
    (userMode && $past(userMode)) |-> !irq);

  p_irq_rise_tick_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(tickEn));

  p_read_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == 2'd0 && !tickEn && !userMode) |=> !irq);

  p_enter_user_low_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(userMode) |=> !irq);

  p_idle_irq_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !regWrEn && !regRdEn && $stable(userMode)) |=> $stable(irq));
endmodule

bind pct_timer pct_checker u_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .userMode(userMode),
  .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr), .irq(irq)
);

// File: tb/tb_pct_timer.sv
module tb_pct_timer;
  logic        clk = 1'b0;
  logic        rstN;
  logic        tickEn, userMode, regWrEn, regRdEn;
  logic [1:0]  regAddr;
  logic [31:0] regWrData, regRdData;
  logic        irq;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  logic [53:0] mCnt;
  logic [21:0] mLim;
  bit          mReached, mIrq, mRun, mMode;
  bit          benchMode;

  pct_timer dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .userMode(userMode),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] expRead(logic [1:0] a);
    logic [31:0] v;
    v = '0;
    if (mMode) begin
      if (a == 2'd0) v = {mReached, mCnt[53:23]};
      if (a == 2'd1) v = {mCnt[22:0], 9'd0};
    end else begin
      if (a == 2'd0) v = {1'b0, mLim, 9'd0};
      if (a == 2'd1) v = {mReached, mCnt[21:0], 9'd0};
    end
    if (a == 2'd3) v = {31'd0, mRun};
    return v;
  endfunction

  task automatic modelStep(bit wr, bit rd, logic [1:0] a, logic [31:0] d, bit tk, bit md);
    bit setR = 0, setI = 0, clrR = 0, clrI = 0;
    logic [21:0] lo;
    if (md != mMode) begin
      if (md) begin mIrq = 1'b0; mLim = '1; end
      mMode = md;
      return;
    end
    if (tk && (!mMode || mRun)) begin
      if (mMode) begin
        if (&mCnt) setR = 1;
        mCnt = mCnt + 54'd1;
      end else begin
        lo = mCnt[21:0] + 22'd1;
        if (mLim != 0 && lo == mLim) begin mCnt = '0; setR = 1; setI = 1; end
        else mCnt = 54'(lo);
      end
    end
    if (wr) begin
      case (a)
        2'd0: if (mMode) begin mCnt[53:23] = d[30:0]; clrR = 1; end
              else begin mLim = d[30:9]; mCnt = '0; clrI = 1; end
        2'd1: if (mMode) begin mCnt[22:0] = d[31:9]; clrR = 1; end
        2'd2: mLim = d[30:9];
        default: mRun = d[0];
      endcase
    end
    if (rd && a == 2'd0 && !mMode) begin clrR = 1; clrI = 1; end
    mReached = setR ? 1'b1 : (clrR ? 1'b0 : mReached);
    mIrq     = setI ? 1'b1 : (clrI ? 1'b0 : mIrq);
  endtask

  task automatic cyc(string tag, bit wr, bit rd, logic [1:0] a, logic [31:0] d, bit tk);
    regWrEn = wr; regRdEn = rd; regAddr = a; regWrData = d;
    tickEn = tk; userMode = benchMode;
    #1;
    if (rd) chk(tag, regRdData, expRead(a));
    @(posedge clk);
    modelStep(wr, rd, a, d, tk, benchMode);
    @(negedge clk);
    chk(mMode ? "R10" : "R3", {31'd0, irq}, {31'd0, mIrq});
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) cyc("R2", 0, 0, 2'd0, 32'd0, 1);
  endtask

  task automatic rd(string tag, logic [1:0] a);
    cyc(tag, 0, 1, a, 32'd0, 0);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    cyc("R4", 1, 0, a, d, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      mismatched++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rstN = 0; tickEn = 0; userMode = 0; regWrEn = 0; regRdEn = 0;
    regAddr = 0; regWrData = 0; benchMode = 0;
    mCnt = '0; mLim = '0; mReached = 0; mIrq = 0; mRun = 1; mMode = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    rd("R1", 2'd0); rd("R1", 2'd1); rd("R1", 2'd2); rd("R1", 2'd3);
    // R2 counting
    ticks(5); rd("R2", 2'd1);
    // R3 limit match, R5 read clear
    wr(2'd0, 32'h0000_0800); rd("R4", 2'd1);
    ticks(4); rd("R3", 2'd1);
    rd("R5", 2'd0); rd("R5", 2'd1);
    // R6 ignored write
    ticks(2); wr(2'd1, 32'hFFFF_FFFF); rd("R6", 2'd1); rd("R6", 2'd0);
    // R4 limit without reset
    wr(2'd2, 32'h0000_1000); rd("R4", 2'd1); rd("R4", 2'd2); rd("R4", 2'd0);
    // R7 run bit ignored in timer mode
    wr(2'd3, 32'd0); rd("R7", 2'd3); ticks(3); rd("R7", 2'd1);
    // R3 free run
    wr(2'd0, 32'd0); ticks(10); rd("R3", 2'd1);
    // build pending irq then R11 transition with run=0
    wr(2'd0, 32'h0000_0400); ticks(3); rd("R3", 2'd1);
    benchMode = 1; cyc("R11", 0, 0, 2'd0, 32'd0, 1);
    ticks(3); rd("R11", 2'd1); rd("R11", 2'd0);
    // R8 run and carry
    cyc("R8", 1, 0, 2'd3, 32'd1, 0); ticks(2); rd("R8", 2'd1);
    cyc("R9", 1, 0, 2'd0, 32'h1234_5678, 0);
    cyc("R9", 1, 0, 2'd1, 32'hFFFF_FE00, 0);
    rd("R9", 2'd0); ticks(1); rd("R8", 2'd0); rd("R8", 2'd1);
    // R10 max wrap
    cyc("R10", 1, 0, 2'd0, 32'h7FFF_FFFF, 0);
    cyc("R10", 1, 0, 2'd1, 32'hFFFF_FE00, 0);
    ticks(1); rd("R10", 2'd0); rd("R10", 2'd1); ticks(2);
    cyc("R9", 1, 0, 2'd1, 32'h0000_0200, 0); rd("R9", 2'd0);
    // R12 return with run=0, R11 forced limit
    cyc("R12", 1, 0, 2'd3, 32'd0, 0);
    benchMode = 0; cyc("R12", 0, 0, 2'd0, 32'd0, 0);
    rd("R11", 2'd0); ticks(3); rd("R12", 2'd1); rd("R12", 2'd3);
    // mixed traffic
    wr(2'd0, 32'h0000_0600);
    for (int i = 0; i < 700; i++) begin
      int unsigned r = $urandom;
      bit          w, q;
      logic [1:0]  a;
      logic [31:0] d;
      if (r % 60 == 0) begin
        benchMode = !benchMode;
        cyc("R11", 0, 0, 2'd0, 32'd0, r[9]);
      end else begin
        w = (r[3:0] == 4'd0);
        q = !w && (r[5:4] == 2'd0);
        a = r[7:6];
        d = $urandom;
        if (w && !benchMode && a != 2'd3) d = {21'd0, 2'd0, d[11:9] + 3'd1, 9'd0};
        if (w && benchMode && a == 2'd0) d = {29'd0, d[2:0]};
        if (w && a == 2'd3) d = {31'd0, r[20]};
        cyc(benchMode ? "R8" : "R2", w, q, a, d, !w && r[8]);
      end
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule